// File: doc/BRIEF.md
# Pin Interrupt Aggregator with Half-Port Byte Routing

This block collects up to 32 pin interrupt channels from a set of 16-bit pin ports and folds them into one interrupt line. Each 16-bit port is seen as two 8-bit halves. A per-byte multiplexer, driven by an assignment register, chooses which half feeds each of the four channel bytes. The even bytes take lower halves and the odd bytes take upper halves. A channel outside the populated ports reads as zero.

The routed bits cross into the clock domain through a two-flop synchronizer. An optional per-channel inversion is then applied. A channel fires only on a 0-to-1 transition of the inverted value. In edge mode the request is latched until software clears it. In level mode the request follows the inverted input. Falling-edge and active-low behaviour come from setting the invert bit. Both-edge behaviour comes from toggling the invert bit after each acknowledge.

Software reaches the block through a small word-addressed register port. Mask, edge mode and invert each use a write-one-to-set address and a write-one-to-clear address, so single bits can be changed without read-modify-write.

Top module: `pin_irq_router`

## Requirements
- R1: After reset, every readable register returns zero and `irq_o` is low. This leaves all channels masked, non-inverted and level-sensitive, with nothing pending.
- R2: Word address 0 holds the assignment register, which routes pins to channel bytes:
  - The field for channel byte k sits at bits [8k+7:8k].
  - Bytes 0 and 2 take the lower 8 bits of the port named by their field.
  - Bytes 1 and 3 take the upper 8 bits of the port named by their field.
  - A field value at or beyond the number of ports feeds zeros.
- R3: A write to address 0 updates only the bytes whose `wstrb_i` bit is set. Writing one 16-bit half leaves the other half unchanged.
- R4: The paired control addresses work as follows:
  - Mask: set at 2, clear at 3.
  - Edge mode: set at 4, clear at 5.
  - Invert: set at 6, clear at 7.
  - In each pair, a 1 in the write data sets or clears that bit, and a 0 leaves it alone. Reading either address of a pair returns the current state.
- R5: A channel's sensed value is its routed pin XOR its invert bit. Only a 0-to-1 change of the sensed value raises a request. A pin change becomes visible in the request register after the third rising clock edge following it.
- R6: In edge mode, a request stays latched until a 1 is written to that bit of address 1. If a new rising edge arrives in the same cycle as that clear, the request stays set.
- R7: In level mode, the request bit equals the sensed value, delayed by the pipeline. Writes to address 1 have no lasting effect on it.
- R8: Setting the invert bit makes a channel respond to falling pins. Toggling the invert bit after each acknowledge catches both edges of a pin.
- R9: `irq_o` is high exactly when some request bit is set whose mask bit is also set. With all mask bits clear, `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PORTS*16 | Pin inputs, port p at bits [16p+15:16p] |
| we_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register word address |
| wstrb_i | input | 4 | Byte strobes, used by the assignment register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with three ports, so the select value 3 is out of range. This lets one routing pattern exercise a real lower half, a real upper half and the zero fill of an empty selection together. With fewer ports than byte fields, lanes that share a port carry the same pin. A single pin therefore raises a pair of channels, one in each 16-bit half. This shows that lower-half routing to byte 0 and to byte 2 agree.

// File: rtl/pint_pkg.sv
package pint_pkg;
    localparam int NCH     = 32;
    localparam int NBYTES  = NCH / 8;
    localparam int HALF_W  = 8;
    localparam int PORT_W  = 2 * HALF_W;
    localparam int FIELD_W = 8;
    localparam int NCTRL   = 3;   // mask, edge, invert

    typedef enum logic [2:0] {
        A_ASSIGN = 3'd0,
        A_REQ    = 3'd1,
        A_MSET   = 3'd2,
        A_MCLR   = 3'd3,
        A_ESET   = 3'd4,
        A_ECLR   = 3'd5,
        A_ISET   = 3'd6,
        A_ICLR   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             set;
        logic             clr;
        logic [NCH-1:0]   bits;
    } setclr_cmd_t;

    function automatic logic [NCH-1:0] apply_setclr(input logic [NCH-1:0] cur,
                                                    input setclr_cmd_t cmd);
        if (cmd.set)      return cur | cmd.bits;
        else if (cmd.clr) return cur & ~cmd.bits;
        else              return cur;
    endfunction

    function automatic logic [NCH-1:0] merge_bytes(input logic [NCH-1:0] old_v,
                                                   input logic [NCH-1:0] new_v,
                                                   input logic [NBYTES-1:0] strb);
        logic [NCH-1:0] r;
        for (int b = 0; b < NBYTES; b++)
            r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/pint_lane_mux.sv
module pint_lane_mux
    import pint_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
    input  logic [NCH-1:0]              assign_i,
    output logic [NCH-1:0]              lanes_o
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam int UPPER = b % 2;   // odd bytes take upper halves
        logic [FIELD_W-1:0] sel;
        logic [HALF_W-1:0]  pick;

        assign sel = assign_i[FIELD_W*b +: FIELD_W];

        always_comb begin
            pick = '0;
            for (int p = 0; p < NUM_PORTS; p++)
                if (sel == FIELD_W'(p))
                    pick = pins_i[PORT_W*p + HALF_W*UPPER +: HALF_W];
        end

        assign lanes_o[HALF_W*b +: HALF_W] = pick;
    end
endmodule

// File: rtl/pint_setclr_reg.sv
module pint_setclr_reg
    import pint_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  setclr_cmd_t    cmd_i,
    output logic [NCH-1:0] state_o
);
    logic [NCH-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= apply_setclr(st_q, cmd_i);
    end

    assign state_o = st_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        cmd_i.set |=> ((state_o & $past(cmd_i.bits)) == $past(cmd_i.bits))); // R4
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.clr && !cmd_i.set) |=> ((state_o & $past(cmd_i.bits)) == '0)); // R4
endmodule

// File: rtl/pint_req_latch.sv
module pint_req_latch
    import pint_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] sensed_i,
    input  logic [NCH-1:0] edge_mode_i,
    input  logic [NCH-1:0] ack_i,
    output logic [NCH-1:0] req_o
);
    logic [NCH-1:0] prev_q, req_q, rise;

    assign rise = sensed_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= sensed_i;
            req_q  <= (edge_mode_i & ((req_q & ~ack_i) | rise))
                    | (~edge_mode_i & sensed_i);
        end
    end

    assign req_o = req_q;

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_q & $past(edge_mode_i & req_q & ~ack_i))
                  == $past(edge_mode_i & req_q & ~ack_i))); // R6
    AST_NEW_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_q & $past(edge_mode_i & sensed_i & ~prev_q))
                  == $past(edge_mode_i & sensed_i & ~prev_q))); // R6
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_q & ~$past(edge_mode_i))
                  == ($past(sensed_i) & ~$past(edge_mode_i)))); // R7
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
    import pint_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*16-1:0]     pins_i,
    input  logic                        we_i,
    input  logic [2:0]                  addr_i,
    input  logic [3:0]                  wstrb_i,
    input  logic [31:0]                 wdata_i,
    output logic [31:0]                 rdata_o,
    output logic                        irq_o
);
    localparam int IDX_MASK = 0;
    localparam int IDX_EDGE = 1;
    localparam int IDX_INV  = 2;

    logic [NCH-1:0] assign_q;
    logic [NCH-1:0] lanes, synced, sensed, req, ack;
    logic [NCH-1:0] ctrl_st [NCTRL];
    setclr_cmd_t    ctrl_cmd [NCTRL];

    // assignment register with byte strobes
    always_ff @(posedge clk) begin
        if (rst)
            assign_q <= '0;
        else if (we_i && addr_i == A_ASSIGN)
            assign_q <= merge_bytes(assign_q, wdata_i, wstrb_i);
    end

    // paired set / clear control registers: mask, edge, invert
    for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
        localparam logic [2:0] SET_A = 3'(2 + 2 * g);
        localparam logic [2:0] CLR_A = 3'(3 + 2 * g);
        assign ctrl_cmd[g].set  = we_i && addr_i == SET_A;
        assign ctrl_cmd[g].clr  = we_i && addr_i == CLR_A;
        assign ctrl_cmd[g].bits = wdata_i;
        pint_setclr_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .cmd_i  (ctrl_cmd[g]),
            .state_o(ctrl_st[g])
        );
    end

    pint_lane_mux #(.NUM_PORTS(NUM_PORTS)) u_mux (
        .pins_i  (pins_i),
        .assign_i(assign_q),
        .lanes_o (lanes)
    );

    pint_sync #(.W(NCH)) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(lanes),
        .q_o(synced)
    );

    assign sensed = synced ^ ctrl_st[IDX_INV];
    assign ack    = (we_i && addr_i == A_REQ) ? wdata_i : '0;

    pint_req_latch u_req (
        .clk        (clk),
        .rst        (rst),
        .sensed_i   (sensed),
        .edge_mode_i(ctrl_st[IDX_EDGE]),
        .ack_i      (ack),
        .req_o      (req)
    );

    always_comb begin
        unique case (reg_addr_e'(addr_i))
            A_ASSIGN:       rdata_o = assign_q;
            A_REQ:          rdata_o = req;
            A_MSET, A_MCLR: rdata_o = ctrl_st[IDX_MASK];
            A_ESET, A_ECLR: rdata_o = ctrl_st[IDX_EDGE];
            default:        rdata_o = ctrl_st[IDX_INV];
        endcase
    end

    assign irq_o = |(req & ctrl_st[IDX_MASK]);

    AST_ASSIGN_HI_KEPT: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == A_ASSIGN && wstrb_i[3:2] == 2'b00)
        |=> $stable(assign_q[31:16])); // R3
    AST_ASSIGN_LO_KEPT: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == A_ASSIGN && wstrb_i[1:0] == 2'b00)
        |=> $stable(assign_q[15:0])); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_st[IDX_MASK] == '0) |-> !irq_o); // R9
endmodule

// File: tb/tb_pin_irq_router.sv
module tb_pin_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP*16-1:0] pins = '0;
    logic            we = 1'b0;
    logic [2:0]      addr = '0;
    logic [3:0]      wstrb = 4'hF;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;
    int              checks = 0;
    int              fails = 0;
    bit              done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pin_irq_router #(.NUM_PORTS(NP)) dut (
        .clk(clk), .rst(rst), .pins_i(pins), .we_i(we), .addr_i(addr),
        .wstrb_i(wstrb), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        we = 1'b0; wstrb = 4'hF;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata, exp, req);
    endtask

    task automatic set_pins(input logic [NP*16-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset register");
        chk({31'h0, irq}, 32'h0, "R1 reset irq");
    endtask

    task automatic t_setclr();
        wr(3'd2, 32'hF0F0_0001);
        rd(3'd2, 32'hF0F0_0001, "R4 mask set");
        wr(3'd3, 32'h0000_0001);
        rd(3'd3, 32'hF0F0_0000, "R4 mask clear, read via clear address");
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0000_8000);
        wr(3'd4, 32'h0000_0002);
        rd(3'd4, 32'h0000_8002, "R4 edge set keeps other bits");
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, 32'h0, "R4 edge clear");
    endtask

    task automatic t_assign();
        wr(3'd0, 32'hFFFF_FFFF, 4'b0011);
        rd(3'd0, 32'h0000_FFFF, "R3 low half write");
        wr(3'd0, 32'h0202_0000, 4'b1100);
        rd(3'd0, 32'h0202_FFFF, "R3 high half write keeps low half");
    endtask

    task automatic t_route_level();
        wr(3'd0, 32'h0300_0201);
        set_pins(48'h9ABC_5678_1234);
        rd(3'd1, 32'h0034_9A78, "R2 routing lanes and empty select");
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 32'h0034_9A78, "R7 level request ignores clear");
        set_pins('0);
        rd(3'd1, 32'h0, "R7 level request follows input low");
        wr(3'd0, 32'h0);
    endtask

    task automatic t_edge_latency();
        wr(3'd4, 32'hFFFF_FFFF);
        @(negedge clk);
        pins = 48'h0002;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 3'd1;
        #1;
        chk(rdata, 32'h0, "R5 not visible after two edges");
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(rdata, 32'h0002_0002, "R5 visible after third edge");
        set_pins('0);
        rd(3'd1, 32'h0002_0002, "R6 edge request stays latched");
        wr(3'd1, 32'h0000_0002);
        rd(3'd1, 32'h0002_0000, "R6 clear one bit");
        wr(3'd1, 32'h0002_0000);
        rd(3'd1, 32'h0, "R6 clear other bit");
    endtask

    task automatic t_invert();
        wr(3'd6, 32'h0004_0004);
        repeat (4) @(posedge clk);
        rd(3'd1, 32'h0004_0004, "R5 inversion applied before detection");
        wr(3'd1, 32'h0004_0004);
        set_pins(48'h0004);
        rd(3'd1, 32'h0, "R8 inverted channel ignores rising pin");
        set_pins('0);
        rd(3'd1, 32'h0004_0004, "R8 inverted channel catches falling pin");
        wr(3'd1, 32'h0004_0004);
        wr(3'd7, 32'h0004_0004);
        repeat (4) @(posedge clk);
        rd(3'd1, 32'h0, "R5 sensed falling gives no request");
    endtask

    task automatic t_both_edges();
        set_pins(48'h0008);
        rd(3'd1, 32'h0008_0008, "R8 both-edge rise");
        wr(3'd1, 32'h0008_0008);
        wr(3'd6, 32'h0008_0008);
        repeat (4) @(posedge clk);
        rd(3'd1, 32'h0, "R8 toggle after ack is quiet");
        set_pins('0);
        rd(3'd1, 32'h0008_0008, "R8 both-edge fall");
        wr(3'd1, 32'h0008_0008);
        wr(3'd7, 32'h0008_0008);
        set_pins(48'h0008);
        rd(3'd1, 32'h0008_0008, "R8 both-edge rise again");
        wr(3'd1, 32'h0008_0008);
        set_pins('0);
    endtask

    task automatic t_priority();
        set_pins(48'h0010);
        wr(3'd1, 32'h0010_0010);
        rd(3'd1, 32'h0, "R6 ack before collision");
        set_pins('0);
        set_pins(48'h0010);
        rd(3'd1, 32'h0010_0010, "R6 pending before collision");
        set_pins('0);
        @(negedge clk);
        pins = 48'h0010;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        we = 1'b1; addr = 3'd1; wdata = 32'h0000_0010;
        @(negedge clk);
        we = 1'b0;
        rd(3'd1, 32'h0010_0010, "R6 new edge beats same-cycle clear");
        wr(3'd1, 32'h0000_0010);
        rd(3'd1, 32'h0010_0000, "R6 later clear takes effect");
    endtask

    task automatic t_irq();
        @(negedge clk);
        chk({31'h0, irq}, 32'h0, "R9 pending but masked");
        wr(3'd2, 32'h0000_0001);
        chk({31'h0, irq}, 32'h0, "R9 mask on idle channel");
        wr(3'd2, 32'h0010_0000);
        chk({31'h0, irq}, 32'h1, "R9 unmasked pending raises irq");
        wr(3'd3, 32'h0010_0000);
        chk({31'h0, irq}, 32'h0, "R9 mask clear drops irq");
        wr(3'd2, 32'h0010_0000);
        wr(3'd1, 32'h0010_0000);
        chk({31'h0, irq}, 32'h0, "R9 ack drops irq");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_setclr();
        repeat (4) @(posedge clk);
        rd(3'd1, 32'h0, "R4 no residue after control writes");
        t_assign();
        t_route_level();
        t_edge_latency();
        t_invert();
        t_both_edges();
        t_priority();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule